// File: doc/BRIEF.md
# Cell-Fault Coverage Tracker for Reversible Gate Cascades

This block measures how far a set of test vectors has gone toward testing a reversible gate cascade under the single-gate cell-fault model. In that model each gate is treated as a black box that may fail on any one of its input value combinations. A set of vectors is therefore complete only when every gate has had every combination of its own input wires applied. A gate with k inputs has 2^k combinations, so the number of faults to cover is the sum of 2^k over the gates.

Software or a test controller first writes a descriptor for each gate slot: how many wires the gate spans (one, two or three, or zero for an unused slot) and which wires they are, ordered controls first and target last. As the test set is applied, the vector present on the wires at a gate's input level is presented together with that gate's slot number. The block records which combination of the gate's wires the vector forms. Each applied test vector adds at most one combination per gate. A fault on a k-input gate is reachable from 2^(n-k) of the 2^n input vectors. After the last vector an end-of-set strobe starts a scan over the slots. The scan ends with a one-cycle done pulse, the count of combinations still unseen, and a flag that is high when that count is zero.

Top module: `cfcov_tracker`

## Requirements
- R1: After reset, scan_busy, scan_done, set_complete and faults_left are all 0, every slot is unused (size 0) and every slot's record of seen combinations is empty.
- R2: A descriptor write (cfg_we high with cfg_gate below NUM_GATES) loads that slot's size code (0 unused, 1, 2 or 3 wires) and its three wire indices, and empties that slot's record. Other slots are unchanged. A write to a slot number of NUM_GATES or more has no effect.
- R3: An observation marks the combination that obs_wires forms on the slot's own wires. Bits on wires the gate does not use have no effect. Two vectors that agree on the gate's wires mark the same single combination, and vectors that differ on them mark different combinations.
- R4: An observation changes only the addressed slot and marks at most one new combination there. An observation addressed to a slot number of NUM_GATES or more, or to an unused slot, changes nothing.
- R5: When set_end is sampled high while idle, scan_busy is high for NUM_GATES cycles. scan_done then pulses high for exactly one cycle, beginning NUM_GATES clock edges after the edge that sampled set_end.
- R6: With the done pulse, faults_left equals the sum over all slots of 2^k minus the number of distinct combinations seen on that slot. An unused slot contributes 0.
- R7: With the done pulse, set_complete is 1 exactly when faults_left is 0. Both outputs hold their values until the next scan finishes.
- R8: While scan_busy is high, descriptor writes, observations, set_clear and further set_end strobes are ignored.
- R9: set_clear empties the records of all slots. It leaves the descriptors unchanged and takes precedence over an observation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_gate | input | GIW | Slot number to write |
| cfg_size | input | 2 | Gate width code: 0 unused, 1 to 3 wires |
| cfg_w0 | input | WIW | First wire (first control, or target for a one-wire gate) |
| cfg_w1 | input | WIW | Second wire |
| cfg_w2 | input | WIW | Third wire (target of a three-wire gate) |
| set_clear | input | 1 | Empty all records to start a new test set |
| obs_valid | input | 1 | Observation strobe |
| obs_gate | input | GIW | Slot that the observed vector belongs to |
| obs_wires | input | NUM_WIRES | Wire values at that gate's input level |
| set_end | input | 1 | End-of-set strobe that starts the scan |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse when the scan result is ready |
| set_complete | output | 1 | Every combination of every used slot has been seen |
| faults_left | output | CW | Number of combinations not yet seen |

## Verification
The assertions check several invariants on every cycle. No record ever holds a combination outside its gate's width. An observation adds at most one combination and never removes one. Writes and clears empty a record on the next cycle. The records stay frozen throughout a scan. The done pulse lasts one cycle, follows a busy period, and the result stays put between scans. Only the bench's scenarios can show that the right combination is counted for a given wire order, that repeated and unused-wire patterns do not inflate coverage, and that the scan total matches a separate count over random descriptors and vectors. The bench scenarios also cover the exact cycle of the done pulse and the case where every slot reaches full coverage.

// File: rtl/cfcov_pkg.sv
package cfcov_pkg;

  localparam int MASK_W = 8;   // room for 2^3 combinations

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_ONE  = 2'd1,
    SZ_TWO  = 2'd2,
    SZ_THREE = 2'd3
  } gate_size_e;

  // Combinations that exist for a gate of the given width.
  function automatic logic [MASK_W-1:0] legal_combos(input logic [1:0] size);
    case (size)
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      2'd3:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] ones8(input logic [MASK_W-1:0] m);
    logic [3:0] c;
    c = '0;
    for (int i = 0; i < MASK_W; i++) c = c + {3'b000, m[i]};
    return c;
  endfunction

endpackage

// File: rtl/cfcov_gate_slot.sv
module cfcov_gate_slot
  import cfcov_pkg::*;
#(
  parameter int NUM_WIRES = 4,
  parameter int WIW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_size,
  input  logic [WIW-1:0]       wr_w0,
  input  logic [WIW-1:0]       wr_w1,
  input  logic [WIW-1:0]       wr_w2,
  input  logic                 clr,
  input  logic                 obs_en,
  input  logic [NUM_WIRES-1:0] obs_vec,
  output logic [MASK_W-1:0]    seen_o,
  output logic [3:0]           unset_o
);

  logic [1:0]        size_q;
  logic [WIW-1:0]    w0_q, w1_q, w2_q;
  logic [MASK_W-1:0] seen_q;

  // Out-of-range wire indices read as 0.
  function automatic logic wire_bit(input logic [NUM_WIRES-1:0] v, input logic [WIW-1:0] idx);
    if (int'(idx) < NUM_WIRES) return v[idx];
    return 1'b0;
  endfunction

  // Combination index: first wire is the most significant bit, target the least.
  logic b0, b1, b2;
  logic [2:0] combo;
  logic       hit;

  always_comb begin
    b0 = wire_bit(obs_vec, w0_q);
    b1 = wire_bit(obs_vec, w1_q);
    b2 = wire_bit(obs_vec, w2_q);
    case (size_q)
      2'd1:    combo = {2'b00, b0};
      2'd2:    combo = {1'b0, b0, b1};
      2'd3:    combo = {b0, b1, b2};
      default: combo = 3'd0;
    endcase
  end

  assign hit = obs_en && (size_q != SZ_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_NONE;
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      seen_q <= '0;
    end else if (wr_en) begin
      size_q <= wr_size;
      w0_q   <= wr_w0;
      w1_q   <= wr_w1;
      w2_q   <= wr_w2;
      seen_q <= '0;
    end else if (clr) begin
      seen_q <= '0;
    end else if (hit) begin
      seen_q[combo] <= 1'b1;
    end
  end

  assign seen_o  = seen_q;
  assign unset_o = ones8(legal_combos(size_q) & ~seen_q);

  assert_mask_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q & ~legal_combos(size_q)) == '0);

  assert_one_new_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> ($countones(seen_q) <= $countones($past(seen_q)) + 1));

  assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

  assert_write_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (seen_q == '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (seen_q == '0));

endmodule

// File: rtl/cfcov_scan.sv
module cfcov_scan #(
  parameter int NUM_GATES = 8,
  parameter int CW = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_GATES-1:0][3:0] unset_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      complete_o,
  output logic [CW-1:0]             missing_o
);

  localparam int IDXW = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(NUM_GATES - 1);

  logic            busy_q, done_q, complete_q;
  logic [IDXW-1:0] idx_q;
  logic [CW-1:0]   acc_q, missing_q;
  logic [CW-1:0]   acc_next;

  assign acc_next = acc_q + CW'(unset_i[idx_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      complete_q <= 1'b0;
      idx_q      <= '0;
      acc_q      <= '0;
      missing_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= acc_next;
        if (idx_q == LAST) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          missing_q  <= acc_next;
          complete_q <= (acc_next == '0);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign complete_o = complete_q;
  assign missing_o  = missing_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(missing_q) && $stable(complete_q)));

  assert_missing_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    missing_q <= CW'(NUM_GATES * 8));

endmodule

// File: rtl/cfcov_tracker.sv
module cfcov_tracker
  import cfcov_pkg::*;
#(
  parameter int NUM_GATES = 8,
  parameter int NUM_WIRES = 4,
  parameter int WIW = (NUM_WIRES > 1) ? $clog2(NUM_WIRES) : 1,
  parameter int GIW = $clog2(NUM_GATES) + 1,
  parameter int CW  = $clog2(NUM_GATES * 8 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [GIW-1:0]       cfg_gate,
  input  logic [1:0]           cfg_size,
  input  logic [WIW-1:0]       cfg_w0,
  input  logic [WIW-1:0]       cfg_w1,
  input  logic [WIW-1:0]       cfg_w2,
  input  logic                 set_clear,
  input  logic                 obs_valid,
  input  logic [GIW-1:0]       obs_gate,
  input  logic [NUM_WIRES-1:0] obs_wires,
  input  logic                 set_end,
  output logic                 scan_busy,
  output logic                 scan_done,
  output logic                 set_complete,
  output logic [CW-1:0]        faults_left
);

  logic                           busy;
  logic                           accept;
  logic [NUM_GATES-1:0]           slot_wr, slot_obs;
  logic [NUM_GATES-1:0][3:0]      slot_unset;
  logic [NUM_GATES-1:0][MASK_W-1:0] seen_all;

  // Nothing outside the scan reaches the slots while a scan runs.
  assign accept = !busy;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_slot
    assign slot_wr[g]  = accept && cfg_we    && (cfg_gate == GIW'(g));
    assign slot_obs[g] = accept && obs_valid && (obs_gate == GIW'(g));

    cfcov_gate_slot #(
      .NUM_WIRES(NUM_WIRES),
      .WIW(WIW)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (slot_wr[g]),
      .wr_size(cfg_size),
      .wr_w0  (cfg_w0),
      .wr_w1  (cfg_w1),
      .wr_w2  (cfg_w2),
      .clr    (accept && set_clear),
      .obs_en (slot_obs[g]),
      .obs_vec(obs_wires),
      .seen_o (seen_all[g]),
      .unset_o(slot_unset[g])
    );
  end

  cfcov_scan #(
    .NUM_GATES(NUM_GATES),
    .CW(CW)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (set_end),
    .unset_i   (slot_unset),
    .busy_o    (busy),
    .done_o    (scan_done),
    .complete_o(set_complete),
    .missing_o (faults_left)
  );

  assign scan_busy = busy;

  assert_frozen_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seen_all));

  assert_single_slot_obs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_obs));

endmodule

// File: tb/cfcov_tracker_tb.sv
module cfcov_tracker_tb;

  localparam int G   = 8;
  localparam int N   = 4;
  localparam int WIW = 2;
  localparam int GIW = 4;
  localparam int CW  = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [GIW-1:0] cfg_gate = '0;
  logic [1:0]     cfg_size = '0;
  logic [WIW-1:0] cfg_w0 = '0, cfg_w1 = '0, cfg_w2 = '0;
  logic           set_clear = 1'b0;
  logic           obs_valid = 1'b0;
  logic [GIW-1:0] obs_gate = '0;
  logic [N-1:0]   obs_wires = '0;
  logic           set_end = 1'b0;
  logic           scan_busy, scan_done, set_complete;
  logic [CW-1:0]  faults_left;

  always #5 clk = ~clk;

  cfcov_tracker #(.NUM_GATES(G), .NUM_WIRES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gate(cfg_gate),
    .cfg_size(cfg_size), .cfg_w0(cfg_w0), .cfg_w1(cfg_w1), .cfg_w2(cfg_w2),
    .set_clear(set_clear), .obs_valid(obs_valid), .obs_gate(obs_gate),
    .obs_wires(obs_wires), .set_end(set_end), .scan_busy(scan_busy),
    .scan_done(scan_done), .set_complete(set_complete), .faults_left(faults_left)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference state
  int m_size [G];
  int m_w    [G][3];
  bit m_seen [G][8];

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_combo(input int g, input logic [N-1:0] v);
    int c = 0;
    for (int j = 0; j < m_size[g]; j++) c = (c << 1) | int'(v[m_w[g][j]]);
    return c;
  endfunction

  function automatic int ref_missing();
    int t = 0;
    for (int g = 0; g < G; g++)
      for (int c = 0; c < (1 << m_size[g]); c++)
        if (m_size[g] != 0 && !m_seen[g][c]) t++;
    return t;
  endfunction

  task automatic do_cfg(input int g, input int sz, input int a, input int b, input int c);
    @(negedge clk);
    cfg_we = 1; cfg_gate = GIW'(g); cfg_size = 2'(sz);
    cfg_w0 = WIW'(a); cfg_w1 = WIW'(b); cfg_w2 = WIW'(c);
    @(negedge clk);
    cfg_we = 0;
    if (g < G) begin
      m_size[g] = sz; m_w[g][0] = a; m_w[g][1] = b; m_w[g][2] = c;
      for (int k = 0; k < 8; k++) m_seen[g][k] = 0;
    end
  endtask

  task automatic do_obs(input int g, input logic [N-1:0] v, input bit with_clear);
    @(negedge clk);
    obs_valid = 1; obs_gate = GIW'(g); obs_wires = v; set_clear = with_clear;
    @(negedge clk);
    obs_valid = 0; set_clear = 0;
    if (with_clear) begin
      for (int q = 0; q < G; q++) for (int k = 0; k < 8; k++) m_seen[q][k] = 0;
    end else if (g < G && m_size[g] != 0) begin
      m_seen[g][ref_combo(g, v)] = 1;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    set_clear = 1;
    @(negedge clk);
    set_clear = 0;
    for (int q = 0; q < G; q++) for (int k = 0; k < 8; k++) m_seen[q][k] = 0;
  endtask

  // Scan with timing checks; poke drives every other input during the busy window.
  task automatic do_scan(input string req, input bit poke);
    int exp_m;
    exp_m = ref_missing();
    @(negedge clk);
    set_end = 1;
    @(negedge clk);
    set_end = 0;
    chk({req, " busy after strobe R5"}, int'(scan_busy), 1);
    if (poke) begin
      cfg_we = 1; cfg_gate = '0; cfg_size = 2'd0;
      set_clear = 1; obs_valid = 1; obs_gate = '0; obs_wires = '1; set_end = 1;
    end
    @(negedge clk);
    cfg_we = 0; set_clear = 0; obs_valid = 0; set_end = 0;
    repeat (G - 2) @(negedge clk);
    chk({req, " no early done R5"}, int'(scan_done), 0);
    @(negedge clk);
    chk({req, " done pulse R5"}, int'(scan_done), 1);
    chk({req, " faults_left R6"}, int'(faults_left), exp_m);
    chk({req, " complete flag R7"}, int'(set_complete), int'(exp_m == 0));
    @(negedge clk);
    chk({req, " done one cycle R5"}, int'(scan_done), 0);
    chk({req, " idle after scan R5"}, int'(scan_busy), 0);
    chk({req, " result held R7"}, int'(faults_left), exp_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int g = 0; g < G; g++) begin
      m_size[g] = 0;
      for (int j = 0; j < 3; j++) m_w[g][j] = 0;
      for (int k = 0; k < 8; k++) m_seen[g][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", int'(scan_busy), 0);
    chk("R1 done", int'(scan_done), 0);
    chk("R1 complete", int'(set_complete), 0);
    chk("R1 faults_left", int'(faults_left), 0);
    do_scan("R1 empty slots", 0);

    // R3: two-input controlled-NOT, control on wire 2, target on wire 0
    do_cfg(0, 2, 2, 0, 0);
    do_scan("R2 fresh slot", 0);
    do_obs(0, 4'b0100, 0);
    do_obs(0, 4'b1110, 0);   // same values on wires 2 and 0
    do_scan("R3 repeat combo", 0);
    do_obs(0, 4'b0001, 0);
    do_obs(0, 4'b0101, 0);
    do_obs(0, 4'b0000, 0);
    do_scan("R3 all four combos", 0);

    // R4: out-of-range slot and unused slot change nothing
    do_obs(G + 3, 4'b1111, 0);
    do_obs(5, 4'b1010, 0);
    do_scan("R4 ignored obs", 0);

    // R2: rewrite empties, out-of-range write ignored
    do_cfg(1, 3, 0, 1, 3);
    do_obs(1, 4'b1011, 0);
    do_cfg(G + 1, 1, 0, 0, 0);
    do_scan("R2 bad write ignored", 0);
    do_cfg(1, 1, 3, 0, 0);
    do_scan("R2 rewrite empties", 0);

    // R9: clear wins over an observation in the same cycle
    do_obs(1, 4'b1000, 0);
    do_obs(1, 4'b0000, 1);
    do_scan("R9 clear priority", 0);

    // R8: all inputs ignored during the scan
    do_obs(0, 4'b0101, 0);
    do_scan("R8 poke during scan", 1);
    do_scan("R8 state unchanged", 0);

    // R7: full coverage with distinct wires on every slot
    for (int g = 0; g < G; g++) do_cfg(g, 1 + (g % 3), g % 4, (g + 1) % 4, (g + 2) % 4);
    for (int g = 0; g < G; g++)
      for (int v = 0; v < 16; v++) do_obs(g, 4'(v), 0);
    do_scan("R7 full coverage", 0);

    // Random rounds: R3 R4 R6
    for (int r = 0; r < 8; r++) begin
      do_clear();
      for (int g = 0; g < G; g++)
        do_cfg(g, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
               int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
      for (int k = 0; k < int'($urandom_range(60, 0)); k++)
        do_obs(int'($urandom_range(G, 0)), 4'($urandom_range(15, 0)), 0);
      do_scan("R6 random round", 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule